// File: doc/BRIEF.md
# Software Interrupt Vector Dispatcher

This block turns a software-interrupt request into a jump to its handler. The request carries an 8-bit interrupt number. The block computes where that number's entry sits in a vector table held in memory. Each entry is three bytes long: a one-byte arm code, followed by a 16-bit handler address. The dispatcher reads both through a byte/word memory read port. If the entry is armed, it decides whether the processor context has to be saved, and then writes the handler address into the instruction pointer.

The block keeps an in-handler flag. On the first, non-nested dispatch it pushes a zero word onto the stack and then asks an external frame sequencer to save a full call frame. Once a handler is running, a further software interrupt only redirects the instruction pointer and saves nothing. A return-from-interrupt input clears the flag and asks the frame sequencer for a normal frame restore. While a dispatch or a restore is in progress, a busy output is high and new requests are not accepted.

Top module: `soft_trap_dispatcher`

## Requirements
- R1: An accepted request reads first a single byte (`mem_rd_word`=0) at address `TABLE_BASE + 3*trap_num`, with `TABLE_BASE` defaulting to 16'h1000.
- R2: If the low byte returned by that first read is anything other than 8'hFF, the request ends with no further read, no stack push, no frame save, no IP write, and the in-handler flag unchanged.
- R3: For an armed entry, the second read is a 16-bit word (`mem_rd_word`=1) at entry address + 1, and its data is the handler address.
- R4: If the in-handler flag is 0 at dispatch, exactly one push of the word 16'h0000 is completed before exactly one frame save, and both come before the IP write.
- R5: If the in-handler flag is 1 at dispatch, no push and no frame save occur; only the IP write happens.
- R6: Each armed dispatch ends with one IP write (`ip_we` high for one cycle) carrying the handler address, and the in-handler flag is 1 afterwards.
- R7: A request is ignored while bit `IE_BIT` (default 1) of `flags_word` is 0: no memory read occurs and `busy` stays 0.
- R8: A return request clears the in-handler flag before `restore_req` rises, and completes one frame restore. When a return and a trap arrive in the same idle cycle, the return wins and the trap is dropped.
- R9: After reset, `in_handler` and `busy` are 0 and all request outputs are low.
- R10: `busy` is high from the cycle after a request is accepted until the operation ends. A request presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Software interrupt request, sampled when idle |
| trap_num | input | 8 | Interrupt number |
| flags_word | input | 16 | Processor flags word; bit IE_BIT enables interrupts |
| reti_req | input | 1 | Return-from-interrupt request |
| mem_rd_en | output | 1 | Memory read request, held until valid |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_word | output | 1 | 1 = 16-bit read, 0 = byte read |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 16 | Read data (byte in the low 8 bits) |
| push_req | output | 1 | Stack push request, held until ack |
| push_data | output | 16 | Word to push (always zero) |
| push_ack | input | 1 | Push done |
| save_req | output | 1 | Frame save request to the frame sequencer |
| save_done | input | 1 | Frame save complete |
| restore_req | output | 1 | Frame restore request to the frame sequencer |
| restore_done | input | 1 | Frame restore complete |
| ip_we | output | 1 | Instruction pointer write strobe |
| ip_wdata | output | 16 | New instruction pointer value |
| in_handler | output | 1 | A handler is running |
| busy | output | 1 | Dispatch or restore in progress |

## Verification
The hardest case to reach is a nested dispatch. The in-handler flag has to be set by an earlier armed dispatch, and no return may come in between. Only then does the block take the path that skips the zero push and the frame save. The stimulus table therefore orders its rows so that an armed first dispatch comes directly before further armed rows, one of them using interrupt number 255 at the top of the table. The test then returns and dispatches again to confirm that saving context resumes. The hold-off while busy is reached by presenting a second request one cycle after the first, while the table reads are still outstanding.

// File: rtl/soft_trap_pkg.sv
package soft_trap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_STAT  = 3'd1,
        ST_VEC   = 3'd2,
        ST_PAD   = 3'd3,
        ST_SAVE  = 3'd4,
        ST_JUMP  = 3'd5,
        ST_REST  = 3'd6
    } disp_state_e;

    localparam logic [7:0] ARM_CODE     = 8'hFF;
    localparam int         ENTRY_BYTES  = 3;

    function automatic logic [15:0] entry_of(input logic [15:0] base,
                                             input logic [7:0]  num);
        entry_of = base + 16'(ENTRY_BYTES) * {8'h00, num};
    endfunction

endpackage

// File: rtl/trap_vec_addr.sv
module trap_vec_addr
    import soft_trap_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          NUM_W      = 8,
    parameter logic [15:0] TABLE_BASE = 16'h1000
) (
    input  logic [NUM_W-1:0] num_i,
    output logic [AW-1:0]    stat_addr_o,
    output logic [AW-1:0]    vec_addr_o
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        stat_addr_o = AW'(entry_of(TABLE_BASE, 8'(num_i)));
        vec_addr_o  = stat_addr_o + ONE;
    end
endmodule

// File: rtl/trap_ctx_flag.sv
module trap_ctx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/trap_seq_ctrl.sv
module trap_seq_ctrl
    import soft_trap_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int NUM_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trap_req_i,
    input  logic [NUM_W-1:0] trap_num_i,
    input  logic             ie_i,
    input  logic             reti_req_i,
    input  logic             in_handler_i,
    output logic [NUM_W-1:0] num_q_o,
    input  logic [AW-1:0]    stat_addr_i,
    input  logic [AW-1:0]    vec_addr_i,
    output logic             mem_rd_en_o,
    output logic [AW-1:0]    mem_rd_addr_o,
    output logic             mem_rd_word_o,
    input  logic             mem_rd_valid_i,
    input  logic [DW-1:0]    mem_rd_data_i,
    output logic             push_req_o,
    input  logic             push_ack_i,
    output logic             save_req_o,
    input  logic             save_done_i,
    output logic             restore_req_o,
    input  logic             restore_done_i,
    output logic             ip_we_o,
    output logic [AW-1:0]    ip_wdata_o,
    output logic             set_flag_o,
    output logic             clr_flag_o,
    output logic             busy_o
);
    disp_state_e      state_q, state_d;
    logic [AW-1:0]    handler_q;
    logic             accept_trap, accept_ret;

    assign accept_ret  = (state_q == ST_IDLE) && reti_req_i;
    assign accept_trap = (state_q == ST_IDLE) && !reti_req_i && trap_req_i && ie_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_ret)       state_d = ST_REST;
                else if (accept_trap) state_d = ST_STAT;
            end
            ST_STAT: if (mem_rd_valid_i)
                         state_d = (mem_rd_data_i[7:0] == ARM_CODE) ? ST_VEC : ST_IDLE;
            ST_VEC:  if (mem_rd_valid_i)
                         state_d = in_handler_i ? ST_JUMP : ST_PAD;
            ST_PAD:  if (push_ack_i)     state_d = ST_SAVE;
            ST_SAVE: if (save_done_i)    state_d = ST_JUMP;
            ST_JUMP:                     state_d = ST_IDLE;
            ST_REST: if (restore_done_i) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            num_q_o   <= '0;
            handler_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept_trap)                            num_q_o   <= trap_num_i;
            if (state_q == ST_VEC && mem_rd_valid_i)    handler_q <= AW'(mem_rd_data_i);
        end
    end

    always_comb begin
        mem_rd_en_o   = (state_q == ST_STAT) || (state_q == ST_VEC);
        mem_rd_word_o = (state_q == ST_VEC);
        mem_rd_addr_o = (state_q == ST_VEC) ? vec_addr_i : stat_addr_i;
        push_req_o    = (state_q == ST_PAD);
        save_req_o    = (state_q == ST_SAVE);
        restore_req_o = (state_q == ST_REST);
        ip_we_o       = (state_q == ST_JUMP);
        ip_wdata_o    = handler_q;
        set_flag_o    = (state_q == ST_JUMP);
        clr_flag_o    = accept_ret;
        busy_o        = (state_q != ST_IDLE);
    end

    // R9: nothing is requested while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !(mem_rd_en_o || push_req_o || save_req_o || restore_req_o || ip_we_o));

    // R7: a trap with interrupts disabled leaves the block idle
    p_ignore_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && trap_req_i && !ie_i && !reti_req_i) |=> !busy_o);

    // R2: a disarmed entry ends the request
    p_disarmed_ends_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_en_o && !mem_rd_word_o && mem_rd_valid_i && mem_rd_data_i[7:0] != ARM_CODE)
        |=> !busy_o);

    // R4: the frame save starts right after the zero push
    p_pad_before_save_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(save_req_o) |-> $past(push_req_o));

    // R5: no context save while a handler is active
    p_nested_no_save_r5: assert property (@(posedge clk) disable iff (rst)
        (push_req_o || save_req_o) |-> !in_handler_i);

    // R10: a request seen while busy does not restart the sequence
    p_holdoff_r10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && mem_rd_en_o && !mem_rd_valid_i) |=> (busy_o && $stable(mem_rd_addr_o)));
endmodule

// File: rtl/soft_trap_dispatcher.sv
module soft_trap_dispatcher
    import soft_trap_pkg::*;
#(
    parameter int          AW         = 16,
    parameter int          DW         = 16,
    parameter int          NUM_W      = 8,
    parameter int          FLAGS_W    = 16,
    parameter int          IE_BIT     = 1,
    parameter logic [15:0] TABLE_BASE = 16'h1000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               trap_req,
    input  logic [NUM_W-1:0]   trap_num,
    input  logic [FLAGS_W-1:0] flags_word,
    input  logic               reti_req,
    output logic               mem_rd_en,
    output logic [AW-1:0]      mem_rd_addr,
    output logic               mem_rd_word,
    input  logic               mem_rd_valid,
    input  logic [DW-1:0]      mem_rd_data,
    output logic               push_req,
    output logic [DW-1:0]      push_data,
    input  logic               push_ack,
    output logic               save_req,
    input  logic               save_done,
    output logic               restore_req,
    input  logic               restore_done,
    output logic               ip_we,
    output logic [AW-1:0]      ip_wdata,
    output logic               in_handler,
    output logic               busy
);
    logic [NUM_W-1:0] num_q;
    logic [AW-1:0]    stat_addr, vec_addr;
    logic             set_flag, clr_flag;

    assign push_data = '0;

    trap_vec_addr #(.AW(AW), .NUM_W(NUM_W), .TABLE_BASE(TABLE_BASE)) u_addr (
        .num_i       (num_q),
        .stat_addr_o (stat_addr),
        .vec_addr_o  (vec_addr)
    );

    trap_ctx_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_flag),
        .clr_i  (clr_flag),
        .flag_o (in_handler)
    );

    trap_seq_ctrl #(.AW(AW), .DW(DW), .NUM_W(NUM_W)) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .trap_req_i     (trap_req),
        .trap_num_i     (trap_num),
        .ie_i           (flags_word[IE_BIT]),
        .reti_req_i     (reti_req),
        .in_handler_i   (in_handler),
        .num_q_o        (num_q),
        .stat_addr_i    (stat_addr),
        .vec_addr_i     (vec_addr),
        .mem_rd_en_o    (mem_rd_en),
        .mem_rd_addr_o  (mem_rd_addr),
        .mem_rd_word_o  (mem_rd_word),
        .mem_rd_valid_i (mem_rd_valid),
        .mem_rd_data_i  (mem_rd_data),
        .push_req_o     (push_req),
        .push_ack_i     (push_ack),
        .save_req_o     (save_req),
        .save_done_i    (save_done),
        .restore_req_o  (restore_req),
        .restore_done_i (restore_done),
        .ip_we_o        (ip_we),
        .ip_wdata_o     (ip_wdata),
        .set_flag_o     (set_flag),
        .clr_flag_o     (clr_flag),
        .busy_o         (busy)
    );

    // R6: an IP write leaves the in-handler flag set
    p_jump_sets_flag_r6: assert property (@(posedge clk) disable iff (rst)
        ip_we |=> in_handler);

    // R8: the flag is already clear while a restore is requested
    p_restore_clear_r8: assert property (@(posedge clk) disable iff (rst)
        restore_req |-> !in_handler);
endmodule

// File: tb/soft_trap_dispatcher_bench.sv
module soft_trap_dispatcher_bench;
    localparam logic [15:0] BASE = 16'h1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_req = 1'b0;
    logic [7:0]  trap_num = '0;
    logic [15:0] flags_word = '0;
    logic        reti_req = 1'b0;
    logic        mem_rd_en, mem_rd_word;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic        push_req, save_req, restore_req, ip_we, in_handler, busy;
    logic [15:0] push_data, ip_wdata;
    logic        push_ack = 1'b0, save_done = 1'b0, restore_done = 1'b0;

    always #4 clk = ~clk;

    soft_trap_dispatcher u_soft_trap_dispatcher (
        .clk(clk), .rst(rst), .trap_req(trap_req), .trap_num(trap_num),
        .flags_word(flags_word), .reti_req(reti_req),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_word(mem_rd_word),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .push_req(push_req), .push_data(push_data), .push_ack(push_ack),
        .save_req(save_req), .save_done(save_done),
        .restore_req(restore_req), .restore_done(restore_done),
        .ip_we(ip_we), .ip_wdata(ip_wdata), .in_handler(in_handler), .busy(busy)
    );

    int n_checks = 0, n_fail = 0;
    int n_rd, n_push, n_save, n_rest, n_ip, seq, push_seq, save_seq, ip_seq;
    int bad_rd, bad_push;
    logic [15:0] last_ip;
    logic [7:0]  cur_num, cur_stat;
    logic [15:0] cur_hdl;
    logic        flag_at_rest;
    logic        exp_flag = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory, stack and frame sequencer responders, one cycle after each request
    always @(negedge clk) begin
        if (mem_rd_en && !mem_rd_valid) begin
            mem_rd_valid <= 1'b1;
            n_rd <= n_rd + 1;
            if (!mem_rd_word && mem_rd_addr == BASE + 16'(3 * cur_num) && n_rd == 0)
                mem_rd_data <= {8'h00, cur_stat};
            else if (mem_rd_word && mem_rd_addr == BASE + 16'(3 * cur_num) + 16'd1 && n_rd == 1)
                mem_rd_data <= cur_hdl;
            else begin
                mem_rd_data <= 16'hDEAD;
                bad_rd <= bad_rd + 1;
            end
        end else mem_rd_valid <= 1'b0;

        if (push_req && !push_ack) begin
            push_ack <= 1'b1; n_push <= n_push + 1; push_seq <= seq; seq <= seq + 1;
            if (push_data != 16'h0000) bad_push <= bad_push + 1;
        end else push_ack <= 1'b0;

        if (save_req && !save_done) begin
            save_done <= 1'b1; n_save <= n_save + 1; save_seq <= seq; seq <= seq + 1;
        end else save_done <= 1'b0;

        if (restore_req && !restore_done) begin
            restore_done <= 1'b1; n_rest <= n_rest + 1; flag_at_rest <= in_handler;
        end else restore_done <= 1'b0;

        if (ip_we) begin
            n_ip <= n_ip + 1; last_ip <= ip_wdata; ip_seq <= seq; seq <= seq + 1;
        end
    end

    task automatic clear_counts();
        n_rd = 0; n_push = 0; n_save = 0; n_rest = 0; n_ip = 0; seq = 1;
        push_seq = 0; save_seq = 0; ip_seq = 0; bad_rd = 0; bad_push = 0;
        last_ip = '0; flag_at_rest = 1'b1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic run_trap(input logic [7:0] num, input logic [7:0] st,
                            input logic [15:0] hdl, input logic ie);
        logic armed, saved;
        clear_counts();
        cur_num = num; cur_stat = st; cur_hdl = hdl;
        flags_word = ie ? 16'h0002 : 16'h0000;
        trap_num = num; trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        chk(ie ? "R10 busy after accept" : "R7 busy stays low", 32'(busy), 32'(ie));
        wait_idle();
        armed = ie && (st == 8'hFF);
        saved = armed && !exp_flag;
        chk("R1 R3 table addresses", 32'(bad_rd), 0);
        chk("R7 R2 read count", 32'(n_rd), ie ? (armed ? 2 : 1) : 0);
        chk("R4 R5 push count", 32'(n_push), 32'(saved));
        chk("R4 R5 save count", 32'(n_save), 32'(saved));
        chk("R6 ip write count", 32'(n_ip), 32'(armed));
        if (armed) chk("R6 ip value", 32'(last_ip), 32'(hdl));
        if (saved) begin
            chk("R4 push zero word", 32'(bad_push), 0);
            chk("R4 order push<save<ip", 32'((push_seq < save_seq) && (save_seq < ip_seq)), 1);
        end
        if (armed) exp_flag = 1'b1;
        chk("R2 R6 in_handler", 32'(in_handler), 32'(exp_flag));
    endtask

    task automatic run_ret(input logic with_trap);
        clear_counts();
        cur_num = 8'h05; cur_stat = 8'hFF; cur_hdl = 16'h7777;
        flags_word = 16'h0002;
        reti_req = 1'b1; trap_req = with_trap; trap_num = 8'h05;
        @(negedge clk);
        reti_req = 1'b0; trap_req = 1'b0;
        wait_idle();
        exp_flag = 1'b0;
        chk("R8 restore count", 32'(n_rest), 1);
        chk("R8 flag clear during restore", 32'(flag_at_rest), 0);
        chk("R8 in_handler after return", 32'(in_handler), 0);
        chk("R8 trap dropped", 32'(n_rd + n_ip), 0);
    endtask

    // [32]=ie, [31:24]=num, [23:16]=arm byte, [15:0]=handler
    localparam logic [32:0] VECS [7] = '{
        {1'b0, 8'h04, 8'hFF, 16'h2000},
        {1'b1, 8'h04, 8'h00, 16'h2100},
        {1'b1, 8'h09, 8'hFE, 16'h2200},
        {1'b1, 8'h00, 8'hFF, 16'h3400},
        {1'b1, 8'h11, 8'hFF, 16'h4A5B},
        {1'b1, 8'hFF, 8'hFF, 16'hBEEF},
        {1'b1, 8'h20, 8'h7F, 16'h1234}
    };

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        clear_counts();
        cur_num = 0; cur_stat = 0; cur_hdl = 0;
        repeat (3) @(negedge clk);
        chk("R9 reset in_handler", 32'(in_handler), 0);
        chk("R9 reset busy", 32'(busy), 0);
        chk("R9 reset requests", 32'({mem_rd_en, push_req, save_req, restore_req, ip_we}), 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 7; i++)
            run_trap(VECS[i][31:24], VECS[i][23:16], VECS[i][15:0], VECS[i][32]);

        run_ret(1'b0);
        run_trap(8'h33, 8'hFF, 16'h5150, 1'b1);

        // R10: second request while busy is ignored
        clear_counts();
        cur_num = 8'h02; cur_stat = 8'hFF; cur_hdl = 16'h6060;
        trap_num = 8'h02; trap_req = 1'b1;
        @(negedge clk);
        trap_num = 8'h40;
        @(negedge clk);
        trap_req = 1'b0;
        wait_idle();
        chk("R10 held-off address", 32'(bad_rd), 0);
        chk("R10 one ip write", 32'(n_ip), 1);
        chk("R10 ip value", 32'(last_ip), 32'h6060);

        run_ret(1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule